// File: doc/BRIEF.md
# Prioritized Vector Interrupt Tracker

This block keeps the interrupt state of one processor. It holds three sets of vector flags: the vectors waiting for service, the vectors in service, and for each waiting or in-service vector whether its source is level- or edge-triggered. Interrupt requests come in on a valid/ready stream, each carrying a vector number and a trigger mode. Software sets a task priority through a small register port. From the task priority and the highest in-service vector the block derives a processor priority. It offers the highest waiting vector to the core only when that vector's 16-vector class is above the processor priority.

The core takes the offered vector with a valid/ready handshake. That moves the vector from waiting to in-service. A write to the end-of-interrupt register retires the highest in-service vector. If that vector was level-triggered, the block sends a one-cycle notice carrying the vector back toward the interrupt source side.

Back-pressure rules: `req_ready` is always high, so a request is consumed in every cycle where `req_valid` is high, even when it is dropped. `irq_valid` never waits for `irq_ready`; the offered vector can change or disappear before the core takes it, and a transfer happens only on a clock edge where both are high. The end-of-interrupt notice has no ready signal and lasts exactly one cycle.

Top module: `vec_irq_tracker`

## Requirements
- R1: Each legal vector from 16 to 255 is tracked on its own. This includes vectors on either side of a 32-vector word edge and the two extremes, 0x10 and 0xFF. Requesters never present vectors 0 to 15.
- R2: The processor priority, read at register address 1, is formed from the task priority and the highest in-service vector, where an empty in-service set counts as vector 0. When the upper nibble of the task priority is greater than or equal to the upper nibble of that vector, the processor priority is the full 8-bit task priority. Otherwise it is that vector with its low nibble cleared.
- R3: `irq_vector` shows the highest-numbered waiting vector.
- R4: `irq_valid` is high only when `unit_enable` is high and the waiting vector with its low nibble cleared is strictly greater than the processor priority.
- R5: A handshake (`irq_valid` and `irq_ready` high at a clock edge) clears the offered vector from the waiting set and adds it to the in-service set.
- R6: A write to address 1 retires the highest in-service vector. If that vector was level-triggered, then one cycle after the write `eoi_valid` is high for exactly one cycle, with the vector on `eoi_vector`, and the vector's level flag is cleared. If it was edge-triggered, no notice is sent.
- R7: A write to address 1 while nothing is in service changes nothing and sends no notice.
- R8: A request that arrives while `unit_enable` is low is consumed and discarded, and it does not appear later.
- R9: A level-triggered request for a vector that is already waiting is dropped, and the vector's trigger flag is left as it was. Any other request marks the vector as waiting and sets its trigger flag: 1 for level (`req_level`=1), 0 for edge. `req_ready` is always 1.
- R10: A write to address 0 stores bits [7:0] of `reg_wdata` as the task priority and ignores the upper bits. A read at address 0 returns the task priority, zero-extended.
- R11: After reset all three vector sets and the task priority are zero, `irq_valid` and `eoi_valid` are low, and both register reads return 0.
- R12: When a request and a handshake land on the same edge, the request is applied first. A handshake on the vector being requested leaves that vector not waiting, and a request for a different vector stays waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| unit_enable | input | 1 | Enables request intake and delivery |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_vector | input | 8 | Requested vector |
| req_level | input | 1 | 1 = level-triggered, 0 = edge |
| irq_valid | output | 1 | A deliverable vector is offered |
| irq_ready | input | 1 | Core takes the offered vector |
| irq_vector | output | 8 | Highest waiting vector |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = task priority, 1 = end-of-interrupt (write) / processor priority (read) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| eoi_valid | output | 1 | Level-triggered end-of-interrupt notice |
| eoi_vector | output | 8 | Vector being retired by the notice |

## Verification
The bench builds the block with its default parameters: 256 vectors in eight 32-bit words, an 8-bit priority register, and priority classes 16 vectors wide. With these values it can reach the top vector 0xFF, the lowest legal vector 0x10, and the 0x1F/0x20 word edge, and it can check the strict class comparison at exactly equal classes. End-of-interrupt notices go into a scoreboard queue. This shows that edge, re-requested and dropped level requests send no notice and that nested retirement happens in highest-first order.

// File: rtl/vit_pkg.sv
package vit_pkg;
  typedef enum logic [0:0] {
    SEL_TASKPRI = 1'b0,
    SEL_EOI     = 1'b1
  } vit_sel_e;
endpackage

// File: rtl/vit_hi_find.sv
module vit_hi_find #(
  parameter int W = 32,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  bits,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |bits;
    idx   = '0;
    for (int i = 0; i < W; i++) begin
      if (bits[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/vit_hi_vector.sv
module vit_hi_vector #(
  parameter int NVEC   = 256,
  parameter int WORD_W = 32,
  localparam int VW    = $clog2(NVEC),
  localparam int NWORD = NVEC / WORD_W,
  localparam int BW    = $clog2(WORD_W),
  localparam int WIW   = $clog2(NWORD)
) (
  input  logic [NVEC-1:0] set_bits,
  output logic            found,
  output logic [VW-1:0]   vec
);
  logic [NWORD-1:0] w_any;
  logic [BW-1:0]    w_idx [NWORD];
  logic [WIW-1:0]   top_idx;

  // first level: one encoder per 32-vector word
  for (genvar g = 0; g < NWORD; g++) begin : g_word
    vit_hi_find #(.W(WORD_W)) u_word (
      .bits  (set_bits[g*WORD_W +: WORD_W]),
      .found (w_any[g]),
      .idx   (w_idx[g])
    );
  end

  // second level: pick the highest non-empty word
  vit_hi_find #(.W(NWORD)) u_top (
    .bits  (w_any),
    .found (found),
    .idx   (top_idx)
  );

  assign vec = {top_idx, w_idx[top_idx]};
endmodule

// File: rtl/vit_prio.sv
module vit_prio #(
  parameter int VW        = 8,
  parameter int CLASS_LSB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] taskpri,
  input  logic          isr_found,
  input  logic [VW-1:0] isr_vec,
  input  logic          pend_found,
  input  logic [VW-1:0] pend_vec,
  input  logic          enable,
  output logic [VW-1:0] procpri,
  output logic          deliver
);
  localparam logic [VW-1:0] CMASK = ~VW'((1 << CLASS_LSB) - 1);

  logic [VW-1:0] isr_eff;

  always_comb begin
    isr_eff = isr_found ? isr_vec : '0;
    if ((taskpri & CMASK) >= (isr_eff & CMASK)) procpri = taskpri;
    else                                        procpri = isr_eff & CMASK;
    deliver = enable && pend_found && ((pend_vec & CMASK) > procpri);
  end

  a_r2_ppr_floor: assert property (@(posedge clk) disable iff (!rst_n)
    procpri[VW-1:CLASS_LSB] >= taskpri[VW-1:CLASS_LSB]);

  a_r2_ppr_covers_isr: assert property (@(posedge clk) disable iff (!rst_n)
    isr_found |-> procpri[VW-1:CLASS_LSB] >= isr_vec[VW-1:CLASS_LSB]);
endmodule

// File: rtl/vit_bank.sv
module vit_bank #(
  parameter int NVEC = 256,
  localparam int VW  = $clog2(NVEC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_fire,
  input  logic [VW-1:0]   acc_vec,
  input  logic            acc_level,
  input  logic            ack_fire,
  input  logic [VW-1:0]   ack_vec,
  input  logic            eoi_fire,
  input  logic [VW-1:0]   eoi_vec,
  output logic [NVEC-1:0] pend,
  output logic [NVEC-1:0] isr,
  output logic [NVEC-1:0] tmr,
  output logic            eoi_level
);
  logic [NVEC-1:0] acc_oh, ack_oh, eoi_oh;
  logic            acc_take;
  logic [NVEC-1:0] pend_n, isr_n, tmr_n;

  assign acc_oh    = NVEC'(1) << acc_vec;
  assign ack_oh    = NVEC'(1) << ack_vec;
  assign eoi_oh    = NVEC'(1) << eoi_vec;
  assign eoi_level = tmr[eoi_vec];
  // a repeated level request on an already waiting vector is dropped
  assign acc_take  = acc_fire && !(acc_level && pend[acc_vec]);

  always_comb begin
    pend_n = pend;
    isr_n  = isr;
    tmr_n  = tmr;
    if (eoi_fire) begin
      isr_n = isr_n & ~eoi_oh;
      tmr_n = tmr_n & ~eoi_oh;
    end
    // request first, then the handshake
    if (acc_take) begin
      pend_n = pend_n | acc_oh;
      tmr_n  = acc_level ? (tmr_n | acc_oh) : (tmr_n & ~acc_oh);
    end
    if (ack_fire) begin
      pend_n = pend_n & ~ack_oh;
      isr_n  = isr_n | ack_oh;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      isr  <= '0;
      tmr  <= '0;
    end else begin
      pend <= pend_n;
      isr  <= isr_n;
      tmr  <= tmr_n;
    end
  end

  a_r5_ack_moves: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> isr[$past(ack_vec)] && !pend[$past(ack_vec)]);

  a_r9_level_dup_keeps_tmr: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && acc_level && pend[acc_vec] && !eoi_fire
      |=> tmr[$past(acc_vec)] == $past(tmr[acc_vec]));

  a_r6_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_fire |=> !isr[$past(eoi_vec)]);
endmodule

// File: rtl/vec_irq_tracker.sv
module vec_irq_tracker
  import vit_pkg::*;
#(
  parameter int NVEC      = 256,
  parameter int WORD_W    = 32,
  parameter int REG_W     = 32,
  parameter int CLASS_LSB = 4,
  localparam int VW       = $clog2(NVEC),
  localparam int MIN_VEC  = 1 << CLASS_LSB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             unit_enable,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VW-1:0]    req_vector,
  input  logic             req_level,
  output logic             irq_valid,
  input  logic             irq_ready,
  output logic [VW-1:0]    irq_vector,
  input  logic             reg_we,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             eoi_valid,
  output logic [VW-1:0]    eoi_vector
);
  logic [NVEC-1:0] pend, isr, tmr;
  logic            pend_found, isr_found, eoi_level;
  logic [VW-1:0]   pend_vec, isr_vec, procpri, taskpri;
  logic            acc_fire, ack_fire, eoi_fire, tpr_wr;
  logic            unused_wdata;

  assign req_ready    = 1'b1;
  assign acc_fire     = req_valid && unit_enable;
  assign ack_fire     = irq_valid && irq_ready;
  assign tpr_wr       = reg_we && (vit_sel_e'(reg_addr) == SEL_TASKPRI);
  assign eoi_fire     = reg_we && (vit_sel_e'(reg_addr) == SEL_EOI) && isr_found;
  assign irq_vector   = pend_vec;
  assign unused_wdata = ^reg_wdata[REG_W-1:VW];

  vit_bank #(.NVEC(NVEC)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_fire  (acc_fire),
    .acc_vec   (req_vector),
    .acc_level (req_level),
    .ack_fire  (ack_fire),
    .ack_vec   (irq_vector),
    .eoi_fire  (eoi_fire),
    .eoi_vec   (isr_vec),
    .pend      (pend),
    .isr       (isr),
    .tmr       (tmr),
    .eoi_level (eoi_level)
  );

  vit_hi_vector #(.NVEC(NVEC), .WORD_W(WORD_W)) u_pend_hi (
    .set_bits (pend),
    .found    (pend_found),
    .vec      (pend_vec)
  );

  vit_hi_vector #(.NVEC(NVEC), .WORD_W(WORD_W)) u_isr_hi (
    .set_bits (isr),
    .found    (isr_found),
    .vec      (isr_vec)
  );

  vit_prio #(.VW(VW), .CLASS_LSB(CLASS_LSB)) u_prio (
    .clk        (clk),
    .rst_n      (rst_n),
    .taskpri    (taskpri),
    .isr_found  (isr_found),
    .isr_vec    (isr_vec),
    .pend_found (pend_found),
    .pend_vec   (pend_vec),
    .enable     (unit_enable),
    .procpri    (procpri),
    .deliver    (irq_valid)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taskpri    <= '0;
      eoi_valid  <= 1'b0;
      eoi_vector <= '0;
    end else begin
      if (tpr_wr) taskpri <= reg_wdata[VW-1:0];
      eoi_valid <= eoi_fire && eoi_level;
      if (eoi_fire) eoi_vector <= isr_vec;
    end
  end

  always_comb begin
    if (vit_sel_e'(reg_addr) == SEL_TASKPRI) reg_rdata = REG_W'(taskpri);
    else                                     reg_rdata = REG_W'(procpri);
  end

  a_r1_legal_vec: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && unit_enable |-> req_vector >= VW'(MIN_VEC));

  a_r6_notice_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid |-> $past(reg_we && reg_addr));

  a_r7_empty_eoi_silent: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr && !isr_found |=> !eoi_valid);

  a_r4_above_in_service: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && isr_found |-> irq_vector[VW-1:CLASS_LSB] > isr_vec[VW-1:CLASS_LSB]);
endmodule

// File: tb/vec_irq_tracker_bench.sv
`timescale 1ns/1ps
module vec_irq_tracker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        unit_enable = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_vector = '0;
  logic        req_level = 1'b0;
  logic        irq_valid;
  logic        irq_ready = 1'b0;
  logic [7:0]  irq_vector;
  logic        reg_we = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        eoi_valid;
  logic [7:0]  eoi_vector;

  int checks = 0;
  int bad = 0;
  logic [7:0] exp_q [$];

  always #2.5 clk = ~clk;

  vec_irq_tracker u_vec_irq_tracker (
    .clk, .rst_n, .unit_enable, .req_valid, .req_ready, .req_vector, .req_level,
    .irq_valid, .irq_ready, .irq_vector, .reg_we, .reg_addr, .reg_wdata,
    .reg_rdata, .eoi_valid, .eoi_vector
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] v, input logic lvl);
    @(posedge clk); #1;
    req_valid = 1'b1; req_vector = v; req_level = lvl;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    reg_addr = a; #0.5;
    d = reg_rdata;
  endtask

  task automatic take(input string tag, input logic [7:0] exp);
    @(posedge clk); #1;
    chk(tag, {31'd0, irq_valid}, 32'd1);
    chk(tag, {24'd0, irq_vector}, {24'd0, exp});
    irq_ready = 1'b1;
    @(posedge clk); #1;
    irq_ready = 1'b0;
  endtask

  task automatic eoi(input logic lvl, input logic [7:0] v);
    if (lvl) exp_q.push_back(v);
    wr(1'b1, 32'd0);
  endtask

  task automatic ppr_is(input string tag, input logic [7:0] exp);
    logic [31:0] d;
    rd(1'b1, d);
    chk(tag, d, {24'd0, exp});
  endtask

  task automatic irq_is(input string tag, input logic v, input logic [7:0] vec);
    chk(tag, {31'd0, irq_valid}, {31'd0, v});
    if (v) chk(tag, {24'd0, irq_vector}, {24'd0, vec});
  endtask

  // monitor: every notice must match the next queued expectation (R6)
  always @(negedge clk) begin
    if (rst_n && eoi_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R6 unexpected notice actual=%0h expected=none", eoi_vector);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (eoi_vector !== e) begin
          bad++;
          $display("FAIL R6 notice vector actual=%0h expected=%0h", eoi_vector, e);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(posedge clk);
    #1;
    rst_n = 1'b1;
    #1;
    // R11 reset state
    chk("R11 irq_valid", {31'd0, irq_valid}, 32'd0);
    chk("R11 eoi_valid", {31'd0, eoi_valid}, 32'd0);
    rd(1'b0, d); chk("R11 taskpri", d, 32'd0);
    ppr_is("R11 procpri", 8'h00);
    chk("R9 req_ready", {31'd0, req_ready}, 32'd1);
    unit_enable = 1'b1;

    // R3 highest waiting vector
    send(8'h31, 1'b0);
    irq_is("R3 single", 1'b1, 8'h31);
    send(8'h52, 1'b1);
    irq_is("R3 higher", 1'b1, 8'h52);
    take("R5 take 52", 8'h52);
    irq_is("R4 class below ppr", 1'b0, 8'h00);
    ppr_is("R2 isr class", 8'h50);

    // R10 task priority write
    wr(1'b0, 32'h0000_1234);
    rd(1'b0, d); chk("R10 low byte kept", d, 32'h34);
    ppr_is("R2 isr wins", 8'h50);
    eoi(1'b1, 8'h52);
    ppr_is("R2 tpr wins after eoi", 8'h34);
    irq_is("R4 30 vs 34", 1'b0, 8'h00);
    wr(1'b0, 32'h30);
    irq_is("R4 equal class", 1'b0, 8'h00);
    wr(1'b0, 32'h2F);
    irq_is("R4 strictly above", 1'b1, 8'h31);
    wr(1'b0, 32'h0);
    take("R5 take 31", 8'h31);
    ppr_is("R2 after take 31", 8'h30);
    eoi(1'b0, 8'h31);
    ppr_is("R6 edge retired", 8'h00);

    // R7 empty eoi
    eoi(1'b0, 8'h00);
    ppr_is("R7 ppr unchanged", 8'h00);
    irq_is("R7 nothing offered", 1'b0, 8'h00);

    // R9 level repeat on waiting edge vector is dropped, edge stays
    send(8'h78, 1'b0);
    send(8'h78, 1'b1);
    take("R9 take 78", 8'h78);
    eoi(1'b0, 8'h78);
    // R9 edge after level clears the level flag
    send(8'h77, 1'b1);
    send(8'h77, 1'b0);
    take("R9 take 77", 8'h77);
    eoi(1'b0, 8'h77);
    send(8'h90, 1'b1);
    take("R9 take 90", 8'h90);
    eoi(1'b1, 8'h90);
    ppr_is("R9 clean", 8'h00);

    // R6 nested retirement, highest first
    send(8'h40, 1'b0);
    take("R6 take 40", 8'h40);
    send(8'h60, 1'b1);
    take("R6 take 60", 8'h60);
    ppr_is("R2 nested", 8'h60);
    eoi(1'b1, 8'h60);
    ppr_is("R6 60 retired", 8'h40);
    eoi(1'b0, 8'h40);
    ppr_is("R6 40 retired", 8'h00);

    // R8 disabled requests discarded
    @(posedge clk); #1; unit_enable = 1'b0;
    send(8'h55, 1'b0);
    irq_is("R8 disabled", 1'b0, 8'h00);
    @(posedge clk); #1; unit_enable = 1'b1; #0.5;
    irq_is("R8 not latched", 1'b0, 8'h00);
    send(8'h55, 1'b0);
    irq_is("R8 enabled", 1'b1, 8'h55);
    @(posedge clk); #1; unit_enable = 1'b0; #0.5;
    irq_is("R4 gated by enable", 1'b0, 8'h00);
    @(posedge clk); #1; unit_enable = 1'b1;
    take("R5 take 55", 8'h55);
    eoi(1'b0, 8'h55);

    // R12 request and handshake on one edge
    send(8'hA0, 1'b0);
    @(posedge clk); #1;
    chk("R12 offered A0", {24'd0, irq_vector}, 32'hA0);
    req_valid = 1'b1; req_vector = 8'hC5; req_level = 1'b0; irq_ready = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0; irq_ready = 1'b0;
    irq_is("R12 other vector stays", 1'b1, 8'hC5);
    ppr_is("R12 A0 in service", 8'hA0);
    @(posedge clk); #1;
    req_valid = 1'b1; req_vector = 8'hC5; req_level = 1'b0; irq_ready = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0; irq_ready = 1'b0;
    irq_is("R12 same vector cleared", 1'b0, 8'h00);
    ppr_is("R12 C5 in service", 8'hC0);
    eoi(1'b0, 8'hC5);
    eoi(1'b0, 8'hA0);

    // R1 extremes and word edge
    send(8'h10, 1'b0);
    send(8'hFF, 1'b1);
    irq_is("R1 top vector", 1'b1, 8'hFF);
    take("R1 take FF", 8'hFF);
    ppr_is("R1 ppr F0", 8'hF0);
    eoi(1'b1, 8'hFF);
    irq_is("R1 lowest legal", 1'b1, 8'h10);
    send(8'h1F, 1'b0);
    send(8'h20, 1'b0);
    irq_is("R1 word edge", 1'b1, 8'h20);
    take("R1 take 20", 8'h20);
    eoi(1'b0, 8'h20);
    irq_is("R1 within word", 1'b1, 8'h1F);
    take("R1 take 1F", 8'h1F);
    irq_is("R4 10 vs 10", 1'b0, 8'h00);
    eoi(1'b0, 8'h1F);
    take("R1 take 10", 8'h10);
    eoi(1'b0, 8'h10);
    ppr_is("R1 all retired", 8'h00);

    repeat (3) @(posedge clk);
    #1;
    chk("R6 all notices seen", exp_q.size(), 32'd0);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule